// File: doc/BRIEF.md
# Embedded-Clock Frame Deserializer with Lock

This block takes a serial bit stream, one bit per clock, made of 12-bit frames. Each frame opens with a marker bit of 1, carries ten payload bits and closes with a marker bit of 0. The marker bits act as an embedded clock, so every frame boundary carries a guaranteed 0-to-1 transition. The receiver does not know where frames begin. It holds one candidate 12-bit phase and tests the marker pair at the end of each candidate frame. When a test fails while it is hunting, it moves the candidate by one bit and tries again.

When enough consecutive frames match at the same phase, the active-low lock output goes low. From then on, every frame delivers its ten payload bits on the parallel output together with a one-cycle word strobe. This strobe takes the place of a recovered parallel clock. If a run of frames breaks the marker pattern, lock is dropped and the hunt starts again. Lock is reached from arbitrary payload data. It is reached faster from sync frames, whose payload contains no other 0-to-1 edge that could imitate a frame boundary.

Top module: `frame_deser`

## Requirements
- R1: After reset, lock_n is 1, data_out is 0 and word_stb is 0.
- R2: A frame is the marker bit 1, then payload bits 0 to 9 with bit 0 first, then the marker bit 0. While locked, data_out holds the ten payload bits of the frame whose last bit has just been taken.
- R3: Starting from a correct phase, lock_n stays 1 through the first 7 matching frames. It falls in the same cycle as the strobe of the 8th consecutive matching frame.
- R4: Sync frames use payload 10'h01F, which puts ones in bits 0 to 4. From any starting bit offset, a stream of these frames brings lock within 24 frames.
- R5: A stream of pseudo-random payloads also brings lock. After lock, every recovered word equals the payload that was sent.
- R6: While locked, word_strobe is a one-cycle pulse in the cycle after the last bit of each frame is taken, and is low at all other times.
- R7: While lock_n is 1, data_out is 0 and word_stb is 0.
- R8: While locked, up to 3 consecutive frames with broken markers keep lock, and their payload is still delivered. The 4th consecutive broken frame raises lock_n in the cycle after its last bit, with no strobe.
- R9: After lock is lost, the phase search restarts and a stream of sync frames brings lock again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Serial data bit |
| data_out | output | 10 | Recovered payload word |
| word_stb | output | 1 | One-cycle strobe marking a new recovered word |
| lock_n | output | 1 | Active-low alignment indicator |

## Verification
If the phase register is wrong, strobes land on cycles that do not follow the last bit of a frame. If the bit order is wrong, the recovered words come out reversed. Both show at the ports on the first strobe after lock. An error in the counters shifts the exact frame on which lock_n falls or rises. The bench catches this because it sends a known number of matching or broken frames and checks lock_n on the cycle right after the deciding frame. Any write to the output while unlocked shows as a nonzero word while lock_n is high, and it is seen in the very next cycle.

// File: rtl/frame_deser.sv
module frame_deser #(
  parameter int DW     = 10,
  parameter int LOCK_N = 8,
  parameter int LOSS_N = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_in,
  output logic [DW-1:0] data_out,
  output logic          word_stb,
  output logic          lock_n
);
  localparam int FW = DW + 2;
  localparam int PW = $clog2(FW);
  localparam int GW = (LOCK_N > 1) ? $clog2(LOCK_N) : 1;
  localparam int BW = (LOSS_N > 1) ? $clog2(LOSS_N) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(FW - 1);
  localparam logic [GW-1:0] G_LAST  = GW'(LOCK_N - 1);
  localparam logic [BW-1:0] B_LAST  = BW'(LOSS_N - 1);

  logic [FW-2:0] sr;
  logic [FW-1:0] nxt;
  logic [PW-1:0] ph;
  logic [GW-1:0] gcnt;
  logic [BW-1:0] bcnt;
  logic          locked;

  assign nxt    = {ser_in, sr};
  assign lock_n = ~locked;

  wire edge_now = (ph == PH_LAST);
  wire frm_ok   = nxt[0] & ~nxt[FW-1];
  wire [DW-1:0] payload = nxt[FW-2:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr       <= '0;
      ph       <= '0;
      gcnt     <= '0;
      bcnt     <= '0;
      locked   <= 1'b0;
      data_out <= '0;
      word_stb <= 1'b0;
    end else begin
      sr       <= nxt[FW-1:1];
      word_stb <= 1'b0;
      ph       <= ph + PW'(1);
      if (edge_now) begin
        ph <= '0;
        if (!locked) begin
          if (!frm_ok) begin
            gcnt <= '0;
            ph   <= PW'(1);
          end else if (gcnt == G_LAST) begin
            gcnt     <= '0;
            bcnt     <= '0;
            locked   <= 1'b1;
            data_out <= payload;
            word_stb <= 1'b1;
          end else begin
            gcnt <= gcnt + GW'(1);
          end
        end else if (frm_ok) begin
          bcnt     <= '0;
          data_out <= payload;
          word_stb <= 1'b1;
        end else if (bcnt == B_LAST) begin
          bcnt     <= '0;
          locked   <= 1'b0;
          data_out <= '0;
          ph       <= PW'(1);
        end else begin
          bcnt     <= bcnt + BW'(1);
          data_out <= payload;
          word_stb <= 1'b1;
        end
      end
    end
  end

  AST_STB_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) word_stb |-> !lock_n); // R6
  AST_UNLOCKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) lock_n |-> (data_out == '0 && !word_stb)); // R7
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) word_stb |=> !word_stb); // R6
  AST_LOCK_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n) $fell(lock_n) |-> word_stb); // R3
  AST_LOSS_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n) $rose(lock_n) |-> !word_stb); // R8
endmodule

// File: tb/frame_deser_bench.sv
module frame_deser_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_in = 1'b0;
  logic [9:0] data_out;
  logic       word_stb, lock_n;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  frame_deser u_frame_deser (.clk, .rst_n, .ser_in, .data_out, .word_stb, .lock_n);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic b, input bit last, input logic [9:0] p);
    ser_in = b;
    @(negedge clk);
    if (word_stb) chk(last && data_out == p, "R2/R6 word", int'(data_out), int'(p));
    if (!lock_n && last) chk(word_stb == 1'b1, "R6 strobe per frame", int'(word_stb), 1);
    if (lock_n) chk(data_out == 10'd0 && !word_stb, "R7 idle while unlocked",
                    int'({word_stb, data_out}), 0);
  endtask

  task automatic send(input logic [9:0] p, input bit good);
    step(good, 1'b0, p);
    for (int i = 0; i < 10; i++) step(p[i], 1'b0, p);
    step(!good, 1'b1, p);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ser_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [9:0] next_rand();
    for (int i = 0; i < 10; i++) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[9:0];
  endfunction

  initial begin
    do_reset();
    chk(lock_n && data_out == 0 && !word_stb, "R1 reset state", int'({lock_n, word_stb, data_out}), 'h800);

    // R3: aligned from reset, lock on exactly the 8th frame
    for (int f = 1; f <= 8; f++) begin
      send(10'h01F, 1'b1);
      if (f < 8) chk(lock_n == 1'b1, "R3 still hunting", int'(lock_n), 1);
      else chk(lock_n == 1'b0 && word_stb, "R3 lock on 8th frame", int'({lock_n, word_stb}), 1);
    end

    // R2: known payloads while locked
    send(10'h3A5, 1'b1);
    send(10'h001, 1'b1);
    send(10'h200, 1'b1);
    chk(lock_n == 1'b0, "R2 lock kept on data", int'(lock_n), 0);

    // R8: 3 broken frames keep lock, 4 drop it
    for (int f = 0; f < 3; f++) send(10'h155, 1'b0);
    chk(lock_n == 1'b0, "R8 three broken keep lock", int'(lock_n), 0);
    send(10'h0F0, 1'b1);
    for (int f = 1; f <= 4; f++) begin
      send(10'h2AA, 1'b0);
      if (f < 4) chk(lock_n == 1'b0, "R8 lock held", int'(lock_n), 0);
      else chk(lock_n == 1'b1 && !word_stb, "R8 lock lost on 4th", int'({lock_n, word_stb}), 2);
    end

    // R9: relock after loss
    for (int f = 0; f < 24; f++) send(10'h01F, 1'b1);
    chk(lock_n == 1'b0, "R9 relock after loss", int'(lock_n), 0);

    // R4: sweep all start offsets with sync frames
    for (int k = 0; k < 12; k++) begin
      do_reset();
      for (int j = 0; j < k; j++) step(1'b0, 1'b0, 10'd0);
      for (int f = 0; f < 24; f++) send(10'h01F, 1'b1);
      chk(lock_n == 1'b0, $sformatf("R4 sync lock offset %0d", k), int'(lock_n), 0);
    end

    // R5: random payload lock at several offsets
    for (int k = 0; k < 12; k += 5) begin
      do_reset();
      for (int j = 0; j < k; j++) step(1'b1, 1'b0, 10'd0);
      for (int f = 0; f < 80; f++) send(next_rand(), 1'b1);
      chk(lock_n == 1'b0, $sformatf("R5 random lock offset %0d", k), int'(lock_n), 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule